// File: doc/BRIEF.md
# DRAM PHY Training Sequencer

This block runs a complete DRAM PHY calibration pass in hardware, with no firmware involved. A start pulse with a rank number first programs the PHY's rank selections. Each of the two byte-lane control registers gets a read-modify-write of its write-leveling rank-enable field. The training control register gets a read-modify-write of its rank number, its one-hot rank enable and its gate-training mode bit. The block then launches all eight calibration steps with one command word.

The steps are DRAM reset and init, write leveling, read strobe gate training, write-leveling adjustment, read and write bit deskew, and read and write eye training. While they run, the block reads the PHY status register once per microsecond tick. The flow completes when every expected done bit is set. It times out after a fixed number of polls. Once the status shows completion, the error bits are resolved by priority in step order, and the first failing step is reported.

The PHY sits behind a single-outstanding request/acknowledge register bus. Results stay on the outputs until the next accepted start.

Top module: `dram_train_seq`

## Requirements
- R1: When `start` is high, `busy` is low and `rank` < NUM_RANKS (4), `busy` rises in the next cycle and `done`, `error`, `timeout` and `fail_step` clear. When `rank` >= NUM_RANKS, the next cycle shows `error`=1 with `done`=0, `timeout`=0, `fail_step`=0 and `busy`=0, and no bus request is made.
- R2: Each byte lane i (0, then 1) has a control register at address 0x20 + 0x10*i. That register is read, then written back with bits [7:4] (write-leveling rank enable) cleared, bit 4+rank set, and all other bits preserved.
- R3: The training control register at 0x08 is read, then written back with these changes, all other bits preserved: bits [1:0] = rank, bits [11:8] = one-hot with bit 8+rank set, bit 16 (multi-purpose-register gate mode) set.
- R4: The bus transactions occur in this order: lane 0 read, lane 0 write, lane 1 read, lane 1 write, training read, training write. Then comes one write of 0x3FF to address 0x04, made of bit 0 (global init), bits 1 and 2 (DRAM reset and init) and bits 3..9 (the other seven steps in flow order).
- R5: The status register at 0x0C is read repeatedly. Every status read, including the first, is preceded by exactly TICK_DIV cycles with `bus_req` low.
- R6: Completion means status bits [8:0] are all ones (bit 0 global done, bits 1..8 step done). Error bits seen before completion have no effect, and polling continues.
- R7: In the cycle after the completing status read is acknowledged, `busy` falls and `done`=1. `error` is the OR of status bits [23:16], where bit 16+k is step k's error. `fail_step` is the lowest k whose error bit is set, or 0 when there is none.
- R8: If POLL_LIMIT status reads in a row are incomplete, then in the cycle after the last acknowledge `timeout`=1, `done`=0, `error`=0 and `busy`=0, and no further request is made.
- R9: A `start` pulse while `busy` is high is ignored. The running pass keeps its rank and its transaction sequence.
- R10: While `busy` is low, `bus_req` is low, and `done`, `error`, `timeout` and `fail_step` hold their values until a start is accepted.
- R11: Once `bus_req` is raised, it stays high with `bus_we`, `bus_addr` and `bus_wdata` unchanged until the cycle in which `bus_ack` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse |
| rank | input | RANK_W | Rank to train |
| busy | output | 1 | Training pass in progress |
| done | output | 1 | All steps reported done |
| timeout | output | 1 | Poll budget exhausted |
| error | output | 1 | A step failed, or the rank was invalid |
| fail_step | output | 3 | Index of the first failing step |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Request accepted, read data valid |
| bus_rdata | input | DATA_W | Read data |

## Verification
The bench plays the PHY as a slave with adjustable acknowledge latency. It holds a behavioural model that is updated at the falling edge where the bench drives a stimulus: a start pulse or an acknowledge. That stimulus is seen at the next rising edge, so every status output and the idle bus state are compared at the falling edge one cycle later. Results are therefore due one cycle after the start or the final acknowledge. Each bus transaction is compared against a queue of expected operations at the cycle it is acknowledged. Each status request is checked to follow exactly TICK_DIV request-free cycles.

// File: rtl/dram_train_seq.sv
module dram_train_seq #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int NUM_RANKS   = 4,
  parameter int RANK_W      = 3,
  parameter int NUM_LANES   = 2,
  parameter int TICK_DIV    = 100,
  parameter int POLL_LIMIT  = 50000,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 'h04,
  parameter logic [ADDR_W-1:0] TRN_ADDR    = 'h08,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 'h0C,
  parameter logic [ADDR_W-1:0] LANE_BASE   = 'h20,
  parameter logic [ADDR_W-1:0] LANE_STRIDE = 'h10,
  parameter int LANE_RKEN_LSB = 4,
  parameter int TRN_RANK_LSB  = 0,
  parameter int TRN_RKEN_LSB  = 8,
  parameter int TRN_MPR_BIT   = 16,
  parameter int ERR_LSB       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RANK_W-1:0] rank,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic              error,
  output logic [2:0]        fail_step,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);

  localparam int NSTEP = 8;
  localparam int RF_W  = $clog2(NUM_RANKS);
  localparam int LN_W  = $clog2(NUM_LANES + 1);
  localparam int TK_W  = $clog2(TICK_DIV + 1);
  localparam int PL_W  = $clog2(POLL_LIMIT + 1);
  localparam logic [DATA_W-1:0] CMD_WORD  = DATA_W'({(NSTEP + 2){1'b1}});
  localparam logic [NSTEP:0]    DONE_MASK = '1;

  typedef enum logic [2:0] {S_IDLE, S_LRD, S_LWR, S_TRD, S_TWR, S_CMD, S_WAIT, S_POLL} st_t;

  st_t               state;
  logic [LN_W-1:0]   lane;
  logic [TK_W-1:0]   tick;
  logic [PL_W-1:0]   polls;
  logic [RANK_W-1:0] rank_q;
  logic [DATA_W-1:0] rdat_q;

  wire xfer      = bus_req && bus_ack;
  wire rank_bad  = int'(rank) >= NUM_RANKS;
  wire complete  = (bus_rdata[NSTEP:0] & DONE_MASK) == DONE_MASK;
  wire [NSTEP-1:0] errs = bus_rdata[ERR_LSB +: NSTEP];

  wire [DATA_W-1:0] lane_clr = DATA_W'({NUM_RANKS{1'b1}}) << LANE_RKEN_LSB;
  wire [DATA_W-1:0] lane_set = DATA_W'(1) << (LANE_RKEN_LSB + int'(rank_q));
  wire [DATA_W-1:0] trn_clr  = (DATA_W'({RF_W{1'b1}}) << TRN_RANK_LSB)
                             | (DATA_W'({NUM_RANKS{1'b1}}) << TRN_RKEN_LSB);
  wire [DATA_W-1:0] trn_set  = (DATA_W'(rank_q[RF_W-1:0]) << TRN_RANK_LSB)
                             | (DATA_W'(1) << (TRN_RKEN_LSB + int'(rank_q)))
                             | (DATA_W'(1) << TRN_MPR_BIT);

  function automatic logic [2:0] first_err(input logic [NSTEP-1:0] e);
    first_err = '0;
    for (int i = NSTEP - 1; i >= 0; i--)
      if (e[i]) first_err = 3'(i);
  endfunction

  assign busy    = (state != S_IDLE);
  assign bus_req = state inside {S_LRD, S_LWR, S_TRD, S_TWR, S_CMD, S_POLL};
  assign bus_we  = state inside {S_LWR, S_TWR, S_CMD};

  always_comb begin
    bus_addr  = STAT_ADDR;
    bus_wdata = '0;
    case (state)
      S_LRD:   bus_addr = LANE_BASE + ADDR_W'(lane) * LANE_STRIDE;
      S_LWR: begin
        bus_addr  = LANE_BASE + ADDR_W'(lane) * LANE_STRIDE;
        bus_wdata = (rdat_q & ~lane_clr) | lane_set;
      end
      S_TRD:   bus_addr = TRN_ADDR;
      S_TWR: begin
        bus_addr  = TRN_ADDR;
        bus_wdata = (rdat_q & ~trn_clr) | trn_set;
      end
      S_CMD: begin
        bus_addr  = CMD_ADDR;
        bus_wdata = CMD_WORD;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lane <= '0; tick <= '0; polls <= '0; rank_q <= '0; rdat_q <= '0;
      done <= 1'b0; timeout <= 1'b0; error <= 1'b0; fail_step <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          done <= 1'b0; timeout <= 1'b0; fail_step <= '0;
          error <= rank_bad;
          if (!rank_bad) begin
            rank_q <= rank;
            lane   <= '0;
            polls  <= '0;
            state  <= S_LRD;
          end
        end
        S_LRD: if (xfer) begin
          rdat_q <= bus_rdata;
          state  <= S_LWR;
        end
        S_LWR: if (xfer) begin
          if (lane == LN_W'(NUM_LANES - 1)) state <= S_TRD;
          else begin
            lane  <= lane + 1'b1;
            state <= S_LRD;
          end
        end
        S_TRD: if (xfer) begin
          rdat_q <= bus_rdata;
          state  <= S_TWR;
        end
        S_TWR: if (xfer) state <= S_CMD;
        S_CMD: if (xfer) begin
          tick  <= '0;
          state <= S_WAIT;
        end
        S_WAIT: begin
          if (tick == TK_W'(TICK_DIV - 1)) state <= S_POLL;
          else tick <= tick + 1'b1;
        end
        S_POLL: if (xfer) begin
          if (complete) begin
            done      <= 1'b1;
            error     <= |errs;
            fail_step <= first_err(errs);
            state     <= S_IDLE;
          end else if (polls == PL_W'(POLL_LIMIT - 1)) begin
            timeout <= 1'b1;
            state   <= S_IDLE;
          end else begin
            polls <= polls + 1'b1;
            tick  <= '0;
            state <= S_WAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  // R1
  bad_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && rank_bad |=> !busy && error && !done && !timeout && !bus_req);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(rank_q));

  // R7
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(xfer && bus_addr == STAT_ADDR && !bus_we));

  // R8
  timeout_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !done && !error && !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> $stable({done, error, timeout, fail_step}));

endmodule

// File: tb/dram_train_seq_bench.sv
module dram_train_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 3;
  localparam int PLIM = 12;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] rank = '0;
  logic busy, done, timeout, error, bus_req, bus_we;
  logic [2:0] fail_step;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_train_seq #(.TICK_DIV(TICK), .POLL_LIMIT(PLIM)) u_dram_train_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .rank(rank),
    .busy(busy), .done(done), .timeout(timeout), .error(error), .fail_step(fail_step),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata));

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [256];
  bit exp_busy = 0, exp_done = 0, exp_err = 0, exp_to = 0;
  logic [2:0] exp_fail = '0;
  bit q_we[$];
  logic [7:0] q_addr[$];
  logic [31:0] q_data[$];
  string q_tag[$];
  int lat_cfg = 0, lat = 0, gap = 0, polls = 0, n_inc = 0;
  logic [31:0] inc_stat = '0, fin_stat = '0;
  bit start_req = 0;
  logic [2:0] rank_req = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, expv, cycles);
    end
  endtask

  function automatic logic [2:0] low_err(input logic [31:0] s);
    for (int k = 0; k < 8; k++) if (s[16 + k]) return 3'(k);
    return 3'd0;
  endfunction

  task automatic push(input bit w, input logic [7:0] a, input logic [31:0] d, input string t);
    q_we.push_back(w); q_addr.push_back(a); q_data.push_back(d); q_tag.push_back(t);
  endtask

  task automatic cyc();
    bit cur_busy;
    bit e_we;
    logic [7:0] e_addr;
    logic [31:0] e_data;
    string e_tag;
    @(negedge clk);
    cycles++;
    if (cycles > WDOG) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      chk(busy == exp_busy, "R1 busy", busy, exp_busy);
      chk(done == exp_done, "R7 done", done, exp_done);
      chk(error == exp_err, "R7 error", error, exp_err);
      chk(timeout == exp_to, "R8 timeout", timeout, exp_to);
      chk(fail_step == exp_fail, "R7 fail_step", fail_step, exp_fail);
      if (!exp_busy) chk(!bus_req, "R10 bus idle", bus_req, 0);
    end
    cur_busy = exp_busy;
    if (bus_ack) begin
      bus_ack = 1'b0; lat = 0;
      if (bus_req) gap = 0; else gap++;
    end else if (bus_req) begin
      if (lat == 0 && q_we.size() == 0 && exp_busy)
        chk(gap == TICK, "R5 poll spacing", gap, TICK);
      gap = 0;
      if (lat < lat_cfg) lat++;
      else begin
        if (q_we.size() > 0) begin
          e_we = q_we.pop_front(); e_addr = q_addr.pop_front();
          e_data = q_data.pop_front(); e_tag = q_tag.pop_front();
          chk(bus_we == e_we, e_tag, bus_we, e_we);
          chk(bus_addr == e_addr, e_tag, bus_addr, e_addr);
          if (e_we) chk(bus_wdata == e_data, e_tag, bus_wdata, e_data);
          if (bus_we) mem[bus_addr] = bus_wdata; else bus_rdata = mem[bus_addr];
        end else begin
          chk(!bus_we && bus_addr == 8'h0C, "R5 status read", {bus_we, bus_addr}, 8'h0C);
          polls++;
          if (polls <= n_inc) begin
            bus_rdata = inc_stat;
            if (polls == PLIM) begin exp_busy = 0; exp_to = 1; end
          end else begin
            bus_rdata = fin_stat;
            exp_busy = 0; exp_done = 1;
            exp_err = |fin_stat[23:16];
            exp_fail = low_err(fin_stat);
          end
        end
        bus_ack = 1'b1;
      end
    end else gap++;
    if (start_req) begin
      start = 1'b1; rank = rank_req; start_req = 0;
      if (!cur_busy) begin
        exp_done = 0; exp_to = 0; exp_fail = '0;
        if (rank_req < 3'd4) begin
          exp_busy = 1; exp_err = 0; polls = 0;
          for (int i = 0; i < 2; i++) begin
            push(0, 8'h20 + 8'(i) * 8'h10, 0, "R4 lane read");
            push(1, 8'h20 + 8'(i) * 8'h10,
                 (mem[8'h20 + 8'(i) * 8'h10] & ~32'h0F0) | (32'h1 << (4 + rank_req)), "R2 lane write");
          end
          push(0, 8'h08, 0, "R4 train read");
          push(1, 8'h08, (mem[8'h08] & ~32'hF03) | 32'(rank_req[1:0]) | (32'h1 << (8 + rank_req)) | 32'h10000,
               "R3 train write");
          push(1, 8'h04, 32'h3FF, "R4 command write");
        end else exp_err = 1;
      end
    end else start = 1'b0;
  endtask

  task automatic run(input logic [2:0] r, input int lt, input int ninc, input logic [31:0] istat,
                     input logic [31:0] fstat, input int spur_at, input logic [2:0] spur_rank);
    int k;
    lat_cfg = lt; n_inc = ninc; inc_stat = istat; fin_stat = fstat;
    rank_req = r; start_req = 1;
    cyc();
    k = 0;
    while ((exp_busy || k < 2) && k < 2000) begin
      if (k == spur_at) begin start_req = 1; rank_req = spur_rank; end
      cyc(); k++;
    end
    for (int j = 0; j < 4; j++) cyc();
    chk(q_we.size() == 0, "R4 sequence complete", q_we.size(), 0);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = 32'h0;
    mem[8'h20] = 32'hA5A5_A5A5;
    mem[8'h30] = 32'h5A5A_00F0;
    mem[8'h08] = 32'hFFFF_FFFF;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    chk(!busy && !done && !error && !timeout && fail_step == 0 && !bus_req, "R10 reset state",
        {busy, done, error, timeout, fail_step, bus_req}, 0);
    // R6 R7 clean pass
    run(3'd1, 0, 2, 32'h0000_00FF, 32'h0000_01FF, -1, 0);
    // R6 errors before completion ignored; R7 priority step 3
    run(3'd3, 2, 3, 32'h00FF_01FE, 32'h0028_01FF, -1, 0);
    // R7 last step only
    run(3'd0, 1, 0, 0, 32'h0080_01FF, -1, 0);
    // R7 all failing, step 0 wins
    run(3'd2, 0, 1, 32'h0000_0100, 32'h00FF_01FF, -1, 0);
    // R8 timeout
    run(3'd1, 1, PLIM + 5, 32'h0000_00FF, 32'h0000_01FF, -1, 0);
    // R1 bad rank
    run(3'd5, 0, 0, 0, 32'h0000_01FF, -1, 0);
    // R9 starts during busy ignored
    run(3'd2, 1, 1, 32'h0000_01F0, 32'h0004_01FF, 5, 3'd0);
    run(3'd0, 0, 2, 32'h0001_0000, 32'h0000_01FF, 30, 3'd6);
    // R10 results held across idle cycles
    for (int j = 0; j < 10; j++) cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule